// File: doc/BRIEF.md
# Master-Mode Serial Result Transmitter

This block sends each 14-bit converter result out through a three-wire serial link: a clock it generates itself, a data line and a frame-sync line. All of its timing comes from the system clock. The serial clock half-period is a whole number of system clocks. A conversion starts with a one-cycle `convStart` pulse. The converter reports the end of the conversion with a one-cycle `convDone` pulse, with the raw straight-binary result present on `convResult` in that cycle. The transmitter keeps the last captured result in a holding register that is separate from its shift register.

There are two read modes. In read-during-convert mode (`readDuringConv` high), the frame starts one system clock after the conversion is accepted. It carries the result of the previous conversion, so the transfer overlaps the new conversion. In read-after-convert mode (`readDuringConv` low), the frame starts one system clock after `convDone` and carries the new result. `busy` then stays high until just after the frame ends. In this mode only, a two-bit divider select slows the serial clock. Frame-sync polarity, serial-clock polarity and output coding can each be selected. A pad-enable output tells the pads to release the serial lines when chip select is high.

Top module: `sertx_top`

## Requirements
- R1: A frame holds exactly 14 active serial-clock edges while sync is active. Data goes out MSB first, one bit per active edge, and is stable across each active edge.
- R2: With `straightBin` high, the word is sent unchanged. With `straightBin` low, bit 13 is inverted (two's complement). The coding is applied when the result is captured at `convDone`.
- R3: In read-during-convert mode, sync goes active one system clock after an accepted `convStart`. The frame carries the word captured at the previous `convDone`, which is 0 after reset. A `convDone` that arrives during the frame does not change the bits being sent.
- R4: In read-after-convert mode, the frame starts one system clock after `convDone` and carries the word captured at that `convDone`.
- R5: `busy` rises one system clock after an accepted `convStart`. In read-during-convert mode it falls one system clock after `convDone`. In read-after-convert mode it is still high in the first cycle after sync deasserts and falls one cycle later.
- R6: In read-after-convert mode, the serial-clock period is `2*BASE_HALF << divSel` system clocks: 6, 12, 24 and 48 for `divSel` values 0 to 3 at default parameters. In read-during-convert mode the period is `2*BASE_HALF`, whatever the value of `divSel`.
- R7: With `syncInvert` low, sync is high during a frame and low otherwise. With `syncInvert` high, the levels are the reverse.
- R8: With `clkInvert` low, the serial clock idles low and the rising edge is the active edge. With `clkInvert` high, it idles high and the falling edge is active. The clock is at its idle level outside a frame and when a frame starts.
- R9: `padEn` is high exactly when `csN` is low. When `padEn` is low, the pads hold `sdClk`, `sdOut` and `sync` at high impedance.
- R10: A `convStart` that arrives while `busy` is high or a frame is active is ignored. A `convDone` that arrives when no conversion is running is ignored: it starts no frame and does not change the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | One-cycle conversion start request |
| convDone | input | 1 | One-cycle end-of-conversion strobe |
| convResult | input | 14 | Raw straight-binary result, valid with convDone |
| readDuringConv | input | 1 | 1: read previous result during conversion; 0: read after conversion |
| divSel | input | 2 | Serial-clock slow-down select (read-after-convert only) |
| straightBin | input | 1 | 1: straight binary; 0: two's complement |
| syncInvert | input | 1 | 1: sync active low |
| clkInvert | input | 1 | 1: falling edge active, clock idles high |
| csN | input | 1 | Active-low chip select for the serial outputs |
| busy | output | 1 | Conversion (and, after-convert, transfer) in progress |
| sdClk | output | 1 | Generated serial clock |
| sdOut | output | 1 | Serial data |
| sync | output | 1 | Frame sync |
| padEn | output | 1 | Output pad driver enable |

## Verification
Results are sent in both read modes with straight and two's-complement coding. The values include 0, an MSB-only word and mixed bit patterns, so that coding errors and bit-order errors show up separately. Read-after-convert frames are run at all four divider settings, and one read-during-convert frame is run with the largest divider setting. This separates a correct divider from one that is ignored or applied in the wrong mode. A conversion that finishes while a read-during-convert frame is still running shows whether the frame reads the held word or the incoming one. Stray start and done pulses check that no frame is started or corrupted, and inverted sync and clock settings check the idle levels and which edge is active.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic capture;   // store coded result in holding register
    logic loadHeld;  // shift register <- holding register
    logic loadNew;   // shift register <- incoming coded result
    logic shift;     // advance to next bit
  } txStrobes_t;
endpackage

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobes_t       stb,
  input  logic [WIDTH-1:0] convResult,
  input  logic             straightBin,
  output logic             msbOut
);
  logic [WIDTH-1:0] codedWord;
  logic [WIDTH-1:0] heldWord;
  logic [WIDTH-1:0] shiftWord;

  always_comb begin
    codedWord = convResult;
    if (!straightBin) codedWord[WIDTH-1] = ~convResult[WIDTH-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldWord  <= '0;
      shiftWord <= '0;
    end else begin
      if (stb.capture) heldWord <= codedWord;
      if (stb.loadNew)       shiftWord <= codedWord;
      else if (stb.loadHeld) shiftWord <= heldWord;
      else if (stb.shift)    shiftWord <= {shiftWord[WIDTH-2:0], 1'b0};
    end
  end

  assign msbOut = shiftWord[WIDTH-1];
endmodule

// File: rtl/sertx_control.sv
module sertx_control
  import sertx_pkg::*;
#(
  parameter int WIDTH     = 14,
  parameter int BASE_HALF = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convStart,
  input  logic       convDone,
  input  logic       readDuringConv,
  input  logic [1:0] divSel,
  output txStrobes_t stb,
  output logic       busy,
  output logic       frameAct,
  output logic       sckLvl,
  output logic       racMode
);
  localparam int MAX_HALF = BASE_HALF << 3;
  localparam int HW       = $clog2(MAX_HALF + 1);
  localparam int BW       = $clog2(WIDTH);
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  logic          convRun;
  logic          endDly;
  logic [HW-1:0] halfCnt;
  logic [HW-1:0] halfLen;
  logic [BW-1:0] bitIdx;

  logic startOk, doneOk, rdcStart, racStart, frameStart, tick, lastFall;

  assign startOk    = convStart && !busy && !frameAct;
  assign doneOk     = convDone && convRun;
  assign rdcStart   = startOk && readDuringConv;
  assign racStart   = doneOk && racMode;
  assign frameStart = rdcStart || racStart;
  assign tick       = frameAct && (halfCnt == halfLen - HW'(1));
  assign lastFall   = tick && sckLvl && (bitIdx == LAST_BIT);

  always_comb begin
    stb.capture  = doneOk;
    stb.loadHeld = rdcStart;
    stb.loadNew  = racStart;
    stb.shift    = tick && sckLvl && (bitIdx != LAST_BIT);
  end

  // conversion tracking and busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      convRun <= 1'b0;
      busy    <= 1'b0;
      racMode <= 1'b0;
      endDly  <= 1'b0;
    end else begin
      endDly <= lastFall;
      if (startOk) begin
        convRun <= 1'b1;
        busy    <= 1'b1;
        racMode <= !readDuringConv;
      end else begin
        if (doneOk) convRun <= 1'b0;
        if (doneOk && !racMode) busy <= 1'b0;
        if (endDly && racMode)  busy <= 1'b0;
      end
    end
  end

  // frame engine: serial clock, bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameAct <= 1'b0;
      sckLvl   <= 1'b0;
      halfCnt  <= '0;
      halfLen  <= HW'(BASE_HALF);
      bitIdx   <= '0;
    end else if (frameStart) begin
      frameAct <= 1'b1;
      sckLvl   <= 1'b0;
      halfCnt  <= '0;
      bitIdx   <= '0;
      halfLen  <= racStart ? (HW'(BASE_HALF) << divSel) : HW'(BASE_HALF);
    end else if (frameAct) begin
      if (tick) begin
        halfCnt <= '0;
        sckLvl  <= ~sckLvl;
        if (sckLvl) begin
          if (bitIdx == LAST_BIT) frameAct <= 1'b0;
          else                    bitIdx   <= bitIdx + BW'(1);
        end
      end else begin
        halfCnt <= halfCnt + HW'(1);
      end
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int WIDTH     = 14,
  parameter int BASE_HALF = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             convDone,
  input  logic [WIDTH-1:0] convResult,
  input  logic             readDuringConv,
  input  logic [1:0]       divSel,
  input  logic             straightBin,
  input  logic             syncInvert,
  input  logic             clkInvert,
  input  logic             csN,
  output logic             busy,
  output logic             sdClk,
  output logic             sdOut,
  output logic             sync,
  output logic             padEn
);
  txStrobes_t stb;
  logic frameAct, sckLvl, racMode, msbOut;

  sertx_control #(.WIDTH(WIDTH), .BASE_HALF(BASE_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .readDuringConv(readDuringConv), .divSel(divSel), .stb(stb),
    .busy(busy), .frameAct(frameAct), .sckLvl(sckLvl), .racMode(racMode)
  );

  sertx_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .convResult(convResult),
    .straightBin(straightBin), .msbOut(msbOut)
  );

  assign sdClk = sckLvl ^ clkInvert;
  assign sync  = frameAct ^ syncInvert;
  assign sdOut = frameAct & msbOut;
  assign padEn = ~csN;
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic convDone,
  input logic busy,
  input logic frameAct,
  input logic racMode,
  input logic sdClk,
  input logic clkInvert
);
  // R5 / R10: busy only rises in response to a start request
  p_busy_needs_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(convStart));

  // R5: after-convert busy still covers the cycle in which the frame closes
  p_busy_covers_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    (racMode && $fell(frameAct)) |-> busy);

  // R3 / R4: a frame opens only after a start or done strobe
  p_frame_needs_trigger_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameAct) |-> ($past(convStart) || $past(convDone)));

  // R8: clock sits at its idle level when a frame opens
  p_clock_idle_at_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameAct) |-> (sdClk == clkInvert));

  // R8: clock stays idle between frames
  p_clock_idle_between_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!frameAct && $past(!frameAct)) |-> (sdClk == clkInvert));
endmodule

bind sertx_top sertx_checker u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
  .busy(busy), .frameAct(frameAct), .racMode(racMode),
  .sdClk(sdClk), .clkInvert(clkInvert)
);

// File: tb/test_sertx_top.sv
module test_sertx_top;
  localparam int W    = 14;
  localparam int BASE = 3;

  typedef struct {
    logic [W-1:0] word;
    int           period;
    bit           rac;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convStart = 1'b0, convDone = 1'b0;
  logic [W-1:0] convResult = '0;
  logic readDuringConv = 1'b1;
  logic [1:0] divSel = 2'd0;
  logic straightBin = 1'b1, syncInvert = 1'b0, clkInvert = 1'b0, csN = 1'b1;
  logic busy, sdClk, sdOut, sync, padEn;

  int nChecks = 0, nFail = 0, framesSeen = 0, framesPushed = 0;
  bit finished = 1'b0;
  logic [W-1:0] heldModel = '0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  sertx_top #(.WIDTH(W), .BASE_HALF(BASE)) i_sertx_top (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .convResult(convResult), .readDuringConv(readDuringConv), .divSel(divSel),
    .straightBin(straightBin), .syncInvert(syncInvert), .clkInvert(clkInvert),
    .csN(csN), .busy(busy), .sdClk(sdClk), .sdOut(sdOut), .sync(sync), .padEn(padEn)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit syncActive();
    return (sync ^ syncInvert) == 1'b1;
  endfunction

  // monitor: rebuild each frame at the pins and compare with the scoreboard
  logic prevSync = 1'b0, prevClk = 1'b0, busyNext = 1'b0;
  logic [W-1:0] monWord;
  int monBits, cyc = 0, lastEdge, monPeriod;
  always @(negedge clk) begin
    logic sAct, cLvl;
    expItem_t it;
    cyc++;
    sAct = sync ^ syncInvert;
    cLvl = sdClk ^ clkInvert;
    if (busyNext) begin
      check(busy == 1'b0, "R5 busy low one cycle after sync drop", busy, 0);
      busyNext = 1'b0;
    end
    if (rstN && sAct && !prevSync) begin
      monBits = 0; monWord = '0; lastEdge = -1; monPeriod = -1;
    end
    if (rstN && sAct && cLvl && !prevClk) begin
      monWord = {monWord[W-2:0], sdOut};
      monBits++;
      if (lastEdge >= 0 && monPeriod < 0) monPeriod = cyc - lastEdge;
      lastEdge = cyc;
    end
    if (rstN && !sAct && prevSync) begin
      framesSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected frame", 1, 0);
      end else begin
        it = expQ.pop_front();
        check(monBits == W, "R1 active edges per frame", monBits, W);
        check(monWord == it.word, "R1/R2/R3/R4 frame word", monWord, it.word);
        check(monPeriod == it.period, "R6 serial clock period", monPeriod, it.period);
        if (it.rac) begin
          check(busy == 1'b1, "R5 busy high as sync drops", busy, 1);
          busyNext = 1'b1;
        end
      end
    end
    prevSync = sAct;
    prevClk  = cLvl;
  end

  // driver: one conversion, expected frame pushed into the scoreboard
  task automatic convert(input logic [W-1:0] raw, input bit rdc, input logic [1:0] dv,
                         input bit straight, input int convLen, input bit extraStart);
    expItem_t it;
    logic [W-1:0] coded;
    coded = straight ? raw : {~raw[W-1], raw[W-2:0]};
    @(negedge clk);
    readDuringConv = rdc; divSel = dv; straightBin = straight;
    if (rdc) begin
      it.word = heldModel; it.period = 2 * BASE; it.rac = 1'b0;
    end else begin
      it.word = coded; it.period = (2 * BASE) << dv; it.rac = 1'b1;
    end
    expQ.push_back(it);
    framesPushed++;
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    check(busy == 1'b1, "R5 busy rises after start", busy, 1);
    if (rdc) check(syncActive(), "R3 frame opens one clock after start", sync, !syncInvert);
    else     check(!syncActive(), "R4 no frame before done", sync, syncInvert);
    repeat (convLen / 2) @(negedge clk);
    if (extraStart) begin
      convStart = 1'b1;                  // R10: must be ignored
      @(negedge clk);
      convStart = 1'b0;
    end
    repeat (convLen / 2) @(negedge clk);
    convResult = raw; convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    heldModel = coded;
    if (rdc) begin
      check(busy == 1'b0, "R5 busy falls after done (during-convert)", busy, 0);
      check(syncActive(), "R3 frame still running across done", sync, !syncInvert);
      while (syncActive()) @(negedge clk);
    end else begin
      check(syncActive(), "R4 frame opens one clock after done", sync, !syncInvert);
      while (busy) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(sdClk == clkInvert, "R8 clock idle level", sdClk, clkInvert);
    check(sync == syncInvert, "R7 sync idle level", sync, syncInvert);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R5 reset busy", busy, 0);
    check(sync == 1'b0, "R7 reset sync inactive", sync, 0);
    check(sdClk == 1'b0, "R8 reset clock idle", sdClk, 0);
    check(padEn == 1'b0, "R9 pads released with csN high", padEn, 0);
    csN = 1'b0;
    @(negedge clk);
    check(padEn == 1'b1, "R9 pads driven with csN low", padEn, 1);

    // R3: read during conversion, first frame carries reset value
    convert(14'h2A5C, 1'b1, 2'd0, 1'b1, 20, 1'b0);
    convert(14'h1337, 1'b1, 2'd0, 1'b1, 24, 1'b0);
    // R6: divider ignored in read-during-convert
    convert(14'h0001, 1'b1, 2'd3, 1'b0, 30, 1'b0);
    // R4/R6/R2: read after conversion, all divider settings
    convert(14'h2000, 1'b0, 2'd0, 1'b1, 16, 1'b0);
    convert(14'h2000, 1'b0, 2'd1, 1'b0, 16, 1'b0);
    convert(14'h15A3, 1'b0, 2'd2, 1'b1, 16, 1'b0);
    convert(14'h3FFE, 1'b0, 2'd3, 1'b0, 16, 1'b0);

    // R7/R8: inverted sync and clock
    @(negedge clk); #1;
    syncInvert = 1'b1; clkInvert = 1'b1;
    @(negedge clk);
    check(sync == 1'b1, "R7 inverted sync idles high", sync, 1);
    check(sdClk == 1'b1, "R8 inverted clock idles high", sdClk, 1);
    convert(14'h0C3A, 1'b0, 2'd1, 1'b1, 16, 1'b0);

    // R10: stray done while idle, extra start while busy
    convResult = 14'h3333; convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R10 stray done leaves busy low", busy, 0);
    check(!syncActive(), "R10 stray done starts no frame", sync, syncInvert);
    convert(14'h0F0F, 1'b0, 2'd0, 1'b1, 20, 1'b1);
    @(negedge clk); #1;
    syncInvert = 1'b0; clkInvert = 1'b0;
    // held word must still be the last real conversion
    convert(14'h2222, 1'b1, 2'd0, 1'b1, 20, 1'b0);

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R10 all expected frames seen", expQ.size(), 0);
    check(framesSeen == framesPushed, "R10 frame count", framesSeen, framesPushed);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule